// File: doc/BRIEF.md
# External Interrupt Request and Mask Unit

This block keeps the pending external interrupt requests of one processor and the enable mask that software applies to them, and drives a single level-sensitive interrupt line to the core. Any agent on the system bus can raise a request by writing an interrupt number to a 32-bit word. The number is turned into one request bit, counted from the most significant end. A bus read of the same word returns the pending requests. A periodic timer alarm input raises interrupt number zero in the same way.

On the core side, a narrow register write port lets software acknowledge requests by writing ones to the bits it wants cleared, and load the whole enable mask. A small accept stage combines the interrupt line with the interrupt-enable bit of the processor status word and with a non-maskable request. It reports which of the two kinds the core should take, and the non-maskable kind always wins.

Top module: `eirq_unit`

## Requirements
- R1: After reset the pending register and the mask register are zero, and `irq_out`, `take_nmi`, `take_ext` and `bus_rvalid` are all low.
- R2: A bus write (`bus_valid`=1, `bus_we`=1, `bus_be`=4'hF) of data d sets pending bit W-1-n, where n = d[log2(W)-1:0]. Number 0 sets bit W-1. All higher data bits are ignored.
- R3: Bus writes and timer alarms only set pending bits. A bit that is already pending stays set unless the core clears it.
- R4: A bus access whose `bus_be` is not 4'hF is ignored. A write changes no pending bit, and a read produces no `bus_rvalid`.
- R5: A bus read (`bus_valid`=1, `bus_we`=0, `bus_be`=4'hF) returns the pending register as it was before that clock edge. The value appears on `bus_rdata` with `bus_rvalid` high in the next cycle.
- R6: A core write with `core_sel`=0 clears every pending bit that is 1 in `core_wdata` and leaves the other bits unchanged.
- R7: A core write with `core_sel`=1 replaces the whole mask register with `core_wdata`.
- R8: After every clock edge, `irq_out` is high exactly when the pending register AND the mask register is nonzero.
- R9: A one-cycle pulse on `tmr_alarm` has the same effect as a bus write of interrupt number 0, so it sets bit W-1.
- R10: When a core clear and a set (bus or timer) hit the same bit in one cycle, the bit ends up set.
- R11: `nmi_req` high before an edge makes `take_nmi` high after that edge, regardless of `psw_ien`, the mask or the pending bits.
- R12: `take_ext` is high after an edge only if, before it, `irq_out` and `psw_ien` were high and `nmi_req` was low. `take_nmi` and `take_ext` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe for the request word |
| bus_we | input | 1 | 1 = write an interrupt number, 0 = read pending bits |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | W | Bus write data carrying the interrupt number |
| bus_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| bus_rdata | output | W | Pending register snapshot for a read |
| core_we | input | 1 | Core register write strobe |
| core_sel | input | 1 | 0 = clear pending bits, 1 = load mask |
| core_wdata | input | W | Core write data |
| tmr_alarm | input | 1 | Timer alarm pulse, raises interrupt number 0 |
| psw_ien | input | 1 | Status-word interrupt enable |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_out | output | 1 | Level interrupt line: pending AND mask nonzero |
| take_nmi | output | 1 | Core should take the non-maskable interrupt |
| take_ext | output | 1 | Core should take the external interrupt |

## Verification
The assertions take for granted that each input is steady across a clock edge. They also assume that a timer alarm is a single-cycle pulse, and that a clear-only check applies only in cycles where neither the bus nor the timer sets a bit. The stimulus changes every input only on the falling clock edge. It pulses the timer for one cycle and keeps the core select bit at 0 or 1. To exercise the set-over-clear order, it deliberately combines clears with bus writes and alarms in the same cycle. Every access uses the full byte-enable pattern, except the cases meant to be ignored.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } core_sel_e;

  localparam logic [3:0] BE_WORD = 4'hF;
endpackage

// File: rtl/eirq_num_dec.sv
module eirq_num_dec #(
  parameter int W = 32,
  localparam int IDXW = $clog2(W)
) (
  input  logic [IDXW-1:0] num,
  output logic [W-1:0]    onehot
);
  // number n selects bit W-1-n (reversed order)
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign onehot[i] = (int'(num) == (W - 1 - i));
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_val,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  logic [W-1:0] pend_d;
  logic [W-1:0] mask_d;

  always_comb begin
    // clear first, then set: a fresh request is never lost
    pend_d = (pend_q & ~clr_vec) | set_vec;
    mask_d = mask_we ? mask_val : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= |(pend_d & mask_d);
    end
  end
endmodule

// File: rtl/eirq_accept.sv
module eirq_accept (
  input  logic clk,
  input  logic rst,
  input  logic nmi_req,
  input  logic psw_ien,
  input  logic irq_line,
  output logic take_nmi,
  output logic take_ext
);
  always_ff @(posedge clk) begin
    if (rst) begin
      take_nmi <= 1'b0;
      take_ext <= 1'b0;
    end else begin
      take_nmi <= nmi_req;
      take_ext <= !nmi_req && psw_ien && irq_line;
    end
  end
endmodule

// File: rtl/eirq_unit.sv
module eirq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_valid,
  input  logic         bus_we,
  input  logic [3:0]   bus_be,
  input  logic [W-1:0] bus_wdata,
  output logic         bus_rvalid,
  output logic [W-1:0] bus_rdata,
  input  logic         core_we,
  input  logic         core_sel,
  input  logic [W-1:0] core_wdata,
  input  logic         tmr_alarm,
  input  logic         psw_ien,
  input  logic         nmi_req,
  output logic         irq_out,
  output logic         take_nmi,
  output logic         take_ext
);
  import eirq_pkg::*;

  localparam int IDXW = $clog2(W);

  logic         bus_ok;
  logic         bus_wr;
  logic         bus_rd;
  logic [W-1:0] dec_vec;
  logic [W-1:0] bus_set_vec;
  logic [W-1:0] tmr_vec;
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic         mask_we;
  logic [W-1:0] pend_q;
  logic [W-1:0] mask_q;
  core_sel_e    sel;

  assign sel    = core_sel_e'(core_sel);
  assign bus_ok = bus_valid && (bus_be == BE_WORD);
  assign bus_wr = bus_ok && bus_we;
  assign bus_rd = bus_ok && !bus_we;

  eirq_num_dec #(.W(W)) u_dec (
    .num    (bus_wdata[IDXW-1:0]),
    .onehot (dec_vec)
  );

  assign bus_set_vec = bus_wr ? dec_vec : '0;
  assign tmr_vec     = {tmr_alarm, {(W-1){1'b0}}};
  assign set_vec     = bus_set_vec | tmr_vec;
  assign clr_vec     = (core_we && sel == SEL_PEND) ? core_wdata : '0;
  assign mask_we     = core_we && sel == SEL_MASK;

  eirq_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .mask_we  (mask_we),
    .mask_val (core_wdata),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .irq_q    (irq_out)
  );

  eirq_accept u_acc (
    .clk      (clk),
    .rst      (rst),
    .nmi_req  (nmi_req),
    .psw_ien  (psw_ien),
    .irq_line (irq_out),
    .take_nmi (take_nmi),
    .take_ext (take_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= pend_q;
    end
  end
endmodule

// File: rtl/eirq_unit_chk.sv
module eirq_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_valid,
  input logic         bus_we,
  input logic [3:0]   bus_be,
  input logic         core_we,
  input logic         core_sel,
  input logic [W-1:0] core_wdata,
  input logic         tmr_alarm,
  input logic         nmi_req,
  input logic         bus_rvalid,
  input logic [W-1:0] bus_rdata,
  input logic         irq_out,
  input logic         take_nmi,
  input logic         take_ext,
  input logic [W-1:0] pend_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] bus_set_vec
);
  logic bus_full_wr;
  logic bus_full_rd;
  assign bus_full_wr = bus_valid && bus_we && (bus_be == 4'hF);
  assign bus_full_rd = bus_valid && !bus_we && (bus_be == 4'hF);

  // R8
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(pend_q & mask_q)));

  // R2
  p_bus_set_r2: assert property (@(posedge clk) disable iff (rst)
    bus_full_wr |=> ((pend_q & $past(bus_set_vec)) == $past(bus_set_vec)));

  // R3
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !(core_we && !core_sel) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R6
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (core_we && !core_sel && !tmr_alarm && !bus_full_wr)
      |=> ((pend_q & $past(core_wdata)) == '0));

  // R7
  p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
    (core_we && core_sel) |=> (mask_q == $past(core_wdata)));

  // R9
  p_timer_r9: assert property (@(posedge clk) disable iff (rst)
    tmr_alarm |=> pend_q[W-1]);

  // R5
  p_read_r5: assert property (@(posedge clk) disable iff (rst)
    bus_full_rd |=> (bus_rvalid && bus_rdata == $past(pend_q)));

  // R4
  p_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_full_rd |=> !bus_rvalid);

  // R11
  p_nmi_r11: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> take_nmi);

  // R12
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(take_nmi && take_ext));
endmodule

bind eirq_unit eirq_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_we      (bus_we),
  .bus_be      (bus_be),
  .core_we     (core_we),
  .core_sel    (core_sel),
  .core_wdata  (core_wdata),
  .tmr_alarm   (tmr_alarm),
  .nmi_req     (nmi_req),
  .bus_rvalid  (bus_rvalid),
  .bus_rdata   (bus_rdata),
  .irq_out     (irq_out),
  .take_nmi    (take_nmi),
  .take_ext    (take_ext),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .bus_set_vec (bus_set_vec)
);

// File: tb/eirq_unit_tb.sv
`timescale 1ns/1ps
module eirq_unit_tb;
  localparam int W = 32;
  localparam int IDXW = $clog2(W);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_be = 4'h0;
  logic [W-1:0] bus_wdata = '0;
  logic         bus_rvalid;
  logic [W-1:0] bus_rdata;
  logic         core_we = 1'b0;
  logic         core_sel = 1'b0;
  logic [W-1:0] core_wdata = '0;
  logic         tmr_alarm = 1'b0;
  logic         psw_ien = 1'b0;
  logic         nmi_req = 1'b0;
  logic         irq_out;
  logic         take_nmi;
  logic         take_ext;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_req  = '0;
  logic [W-1:0] exp_mask = '0;
  logic [W-1:0] rd_q[$];

  always #2.5 clk = ~clk;

  eirq_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .core_we(core_we), .core_sel(core_sel), .core_wdata(core_wdata),
    .tmr_alarm(tmr_alarm), .psw_ien(psw_ien), .nmi_req(nmi_req),
    .irq_out(irq_out), .take_nmi(take_nmi), .take_ext(take_ext)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for bus reads
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (rd_q.size() == 0) begin
        chk("R4 unexpected rvalid", 1, 0);
      end else begin
        chk("R5 read data", bus_rdata, rd_q.pop_front());
      end
    end
  end

  // one cycle of stimulus; model updated from the requirements
  task automatic step(input logic bv, input logic bwe, input logic [3:0] be,
                      input logic [W-1:0] bd, input logic cwe, input logic csel,
                      input logic [W-1:0] cd, input logic tmr);
    logic [W-1:0] setv;
    logic [W-1:0] clrv;
    setv = '0;
    clrv = '0;
    bus_valid = bv; bus_we = bwe; bus_be = be; bus_wdata = bd;
    core_we = cwe; core_sel = csel; core_wdata = cd; tmr_alarm = tmr;
    if (bv && !bwe && be == 4'hF) rd_q.push_back(exp_req);
    if (bv && bwe && be == 4'hF) setv[W-1-int'(bd[IDXW-1:0])] = 1'b1;
    if (tmr) setv[W-1] = 1'b1;
    if (cwe && !csel) clrv = cd;
    if (cwe && csel) exp_mask = cd;
    exp_req = (exp_req & ~clrv) | setv;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0;
    core_we = 1'b0; core_sel = 1'b0; core_wdata = '0; tmr_alarm = 1'b0;
    chk("R8 irq level", W'(irq_out), W'(|(exp_req & exp_mask)));
  endtask

  task automatic bwrite(input logic [W-1:0] d);
    step(1, 1, 4'hF, d, 0, 0, '0, 0);
  endtask
  task automatic bread();
    step(1, 0, 4'hF, '0, 0, 0, '0, 0);
  endtask
  task automatic cclr(input logic [W-1:0] d);
    step(0, 0, 4'h0, '0, 1, 0, d, 0);
  endtask
  task automatic cmask(input logic [W-1:0] d);
    step(0, 0, 4'h0, '0, 1, 1, d, 0);
  endtask
  task automatic idle();
    step(0, 0, 4'h0, '0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq reset", W'(irq_out), '0);
    chk("R1 take_nmi reset", W'(take_nmi), '0);
    chk("R1 take_ext reset", W'(take_ext), '0);
    chk("R1 rvalid reset", W'(bus_rvalid), '0);
    bread(); idle();                       // R1 pending reads zero

    bwrite(32'h0000_0000); bread();        // R2 number 0 -> bit 31
    bwrite(32'h0000_0125); bread();        // R2 n=5 -> bit 26, upper bits ignored; R3 bit 31 kept
    bwrite(32'hFFFF_FFFF); bread();        // R2 n=31 -> bit 0; R3
    chk("R2 model", exp_req, 32'h8400_0001);

    step(1, 1, 4'h3, 32'h3, 0, 0, '0, 0);  // R4 partial write ignored
    bread();
    step(1, 0, 4'h1, '0, 0, 0, '0, 0);     // R4 partial read
    chk("R4 no rvalid", W'(bus_rvalid), '0);
    idle();

    cmask(32'h0000_0001);                  // R7 + R8 irq high
    chk("R7 irq after mask", W'(irq_out), 1);
    cclr(32'h0000_0001); bread();          // R6 clear bit 0 only
    chk("R6 irq after clear", W'(irq_out), 0);
    cmask(32'h8000_0000);
    cmask(32'h0400_0000);
    chk("R7 replace keeps bit 26", W'(irq_out), 1);
    cmask(32'h0000_0002);
    chk("R7 replace drops", W'(irq_out), 0);

    cclr(32'hFFFF_FFFF); bread();          // R6 clear all
    step(0, 0, 4'h0, '0, 0, 0, '0, 1);     // R9 timer
    bread(); idle();
    cmask(32'h8000_0000);
    chk("R9 irq from timer", W'(irq_out), 1);

    step(1, 1, 4'hF, 32'd27, 1, 0, 32'h0000_0010, 0); // R10 bus set vs clear
    step(0, 0, 4'h0, '0, 1, 0, 32'h8000_0000, 1);     // R10 timer vs clear
    bread(); idle();
    chk("R10 model", exp_req, 32'h8000_0010);

    psw_ien = 1'b0; idle();
    chk("R12 no take without ien", W'(take_ext), 0);
    psw_ien = 1'b1; idle();
    chk("R12 take_ext", W'(take_ext), 1);
    nmi_req = 1'b1; idle();
    chk("R11 take_nmi", W'(take_nmi), 1);
    chk("R12 nmi wins", W'(take_ext), 0);
    nmi_req = 1'b0; psw_ien = 1'b0; cmask('0);
    nmi_req = 1'b1; idle();
    chk("R11 nmi unmasked", W'(take_nmi), 1);
    nmi_req = 1'b0; idle(); idle();
    chk("R11 nmi released", W'(take_nmi), 0);
    chk("R5 queue drained", W'(rd_q.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule